// File: doc/BRIEF.md
# External Memory Bus Controller

This block runs single-byte reads and writes from a slow processor core to an external 64K x 8 memory over pins it borrows from general-purpose ports. The core raises a request carrying an address, a direction flag and, for writes, a byte. The block then runs one machine cycle, made of two system clock periods, on a 16-bit address bus, an 8-bit bidirectional data bus and two active-low strobes. Read data goes back to the core with a one-cycle response pulse.

Strobe edges sit on half-period boundaries of the system clock. To place them there, the block runs on a clock at twice the system rate, so each rising edge of `clk` marks one half-period slot. A machine cycle is four slots, numbered 0 to 3. Outside an access the address and data pins carry the values held in their port registers, and the block does not drive the data bus.

Top module: `ext_mem_bus`

## Requirements
- R1: After reset the block is idle: `reqReady`=1, `memRdN`=1, `memWrN`=1, `memDataOe`=0, `rspValid`=0.
- R2: While idle, `memAddr` equals `portAddr`, `memDataOut` equals `portData` and `memDataOe` is 0.
- R3: A request taken on a rising edge while `reqReady`=1 starts slot 0 on the next cycle. An access fills exactly four `clk` cycles (slots 0 to 3), with `reqReady` low during them and high in the cycle after slot 3.
- R4: On a write, `memAddr` holds the request address through slots 0 to 3, and `memWrN` is low in slot 2 only. The address is therefore stable for one system clock period before the write strobe falls.
- R5: On a write, `memDataOe`=1 and `memDataOut` equals the write byte in slots 0 to 3. Data is thus driven three half-periods before `memWrN` rises and held one half-period after it.
- R6: On a read, `memAddr` holds the request address in slots 0 to 3, `memRdN` is low in slots 1 and 2, and `memDataOe` stays 0.
- R7: A read samples `memDataIn` on the edge that ends slot 2. `rspValid` is high for slot 3 only, with `rspData` equal to the sampled byte. A change of `memDataIn` in slot 3 does not alter it.
- R8: A request raised while an access is running is ignored. `memAddr` keeps the running address, and no further access starts when it ends.
- R9: A write produces no `rspValid` pulse.
- R10: `memRdN` and `memWrN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period slot clock (twice the system clock) |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core requests an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | High when a request can be taken |
| portAddr | input | 16 | Port register values for the address pins |
| portData | input | 8 | Port register values for the data pins |
| memAddr | output | 16 | Address pins |
| memDataOut | output | 8 | Data pin output value |
| memDataOe | output | 1 | Data bus drive enable for a write |
| memDataIn | input | 8 | Data pins as read |
| memRdN | output | 1 | Read strobe, active low |
| memWrN | output | 1 | Write strobe, active low |
| rspValid | output | 1 | One-cycle read-done pulse |
| rspData | output | 8 | Read byte |

## Verification
A slot counter that is off by one moves the strobe edges by a half-period. The bench compares the strobes, address and drive enable in every slot of every access, so such a shift shows within the first access. A wrong direction latch, or a select that does not return to the port registers, shows in the first idle cycle after an access or as a spurious response pulse. A response that never arrives, or that arrives with the wrong byte, is caught by the scoreboard in the slot-3 cycle of that read.

// File: rtl/ext_mem_bus_pkg.sv
package ext_mem_bus_pkg;
  typedef struct packed {
    logic load;
    logic busOwn;
    logic drvData;
    logic rdStrobe;
    logic wrStrobe;
    logic capture;
  } busStrobes_t;
endpackage

// File: rtl/ext_mem_bus_ctrl.sv
module ext_mem_bus_ctrl
  import ext_mem_bus_pkg::*;
#(
  parameter int HALVES_PER_CLK = 2,
  parameter int CLKS_PER_CYCLE = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output busStrobes_t strb
);
  localparam int SLOTS    = HALVES_PER_CLK * CLKS_PER_CYCLE;
  localparam int SW       = (SLOTS > 2) ? $clog2(SLOTS) : 1;
  localparam int LAST     = SLOTS - 1;
  localparam int EDGE     = SLOTS - 2;
  localparam int RD_FIRST = HALVES_PER_CLK / 2;

  logic          active;
  logic          isWrite;
  logic [SW-1:0] slot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
      slot    <= '0;
    end else if (!active) begin
      if (reqValid) begin
        active  <= 1'b1;
        isWrite <= reqWrite;
        slot    <= '0;
      end
    end else if (slot == SW'(LAST)) begin
      active <= 1'b0;
      slot   <= '0;
    end else begin
      slot <= slot + SW'(1);
    end
  end

  always_comb begin
    reqReady      = !active;
    strb.load     = !active && reqValid;
    strb.busOwn   = active;
    strb.drvData  = active && isWrite;
    strb.rdStrobe = active && !isWrite && (slot >= SW'(RD_FIRST)) && (slot <= SW'(EDGE));
    strb.wrStrobe = active && isWrite && (slot == SW'(EDGE));
    strb.capture  = active && !isWrite && (slot == SW'(EDGE));
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (active && slot != SW'(LAST)) |=> (active && slot == $past(slot) + SW'(1))); // R3
  AST_CYCLE_END: assert property (@(posedge clk) disable iff (!rstN)
    (active && slot == SW'(LAST)) |=> !active); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdStrobe && strb.wrStrobe)); // R10
  AST_WR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.wrStrobe) |=> !strb.wrStrobe); // R4
endmodule

// File: rtl/ext_mem_bus_dpath.sv
module ext_mem_bus_dpath
  import ext_mem_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [DATA_W-1:0] portData,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memRdN,
  output logic              memWrN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      rspValid <= strb.capture;
      if (strb.capture) rspData <= memDataIn;
    end
  end

  always_comb begin
    memAddr    = strb.busOwn  ? addrQ  : portAddr;
    memDataOut = strb.drvData ? wdataQ : portData;
    memDataOe  = strb.drvData;
    memRdN     = !strb.rdStrobe;
    memWrN     = !strb.wrStrobe;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busOwn && $past(strb.busOwn)) |-> $stable(memAddr)); // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memRdN); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
endmodule

// File: rtl/ext_mem_bus.sv
module ext_mem_bus
  import ext_mem_bus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int HALVES_PER_CLK = 2,
  parameter int CLKS_PER_CYCLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [DATA_W-1:0] portData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memRdN,
  output logic              memWrN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  busStrobes_t strb;

  ext_mem_bus_ctrl #(
    .HALVES_PER_CLK(HALVES_PER_CLK),
    .CLKS_PER_CYCLE(CLKS_PER_CYCLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  ext_mem_bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .portAddr(portAddr), .portData(portData), .memDataIn(memDataIn),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memRdN(memRdN), .memWrN(memWrN), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: tb/test_ext_mem_bus.sv
module test_ext_mem_bus;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, portAddr = 16'h1234;
  logic [7:0]  reqWdata = '0, portData = 8'h5A, memDataIn = '0;
  logic        reqReady, memDataOe, memRdN, memWrN, rspValid;
  logic [15:0] memAddr;
  logic [7:0]  memDataOut, rspData;

  int nChecks = 0, nFails = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  ext_mem_bus i_ext_mem_bus (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .portAddr(portAddr), .portData(portData), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memRdN(memRdN), .memWrN(memWrN), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk(reqReady == 1'b1, {tag, " R3 ready"}, 32'(reqReady), 32'd1);
    chk(memAddr == portAddr, {tag, " R2 addr"}, 32'(memAddr), 32'(portAddr));
    chk(memDataOut == portData, {tag, " R2 data"}, 32'(memDataOut), 32'(portData));
    chk(memDataOe == 1'b0 && memRdN && memWrN, {tag, " R2 idle strobes"},
        {29'd0, memDataOe, memRdN, memWrN}, 32'd3);
  endtask

  // Scoreboard monitor: pops expected read bytes as responses arrive.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) chk(1'b0, "R9 unexpected rspValid", 32'd1, 32'd0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(rspData == e, "R7 rspData", 32'(rspData), 32'(e));
      end
    end
    if (rstN) chk(!(!memRdN && !memWrN), "R10 strobes", {30'd0, memRdN, memWrN}, 32'd3);
  end

  task automatic doAccess(input logic wr, input logic [15:0] a, input logic [7:0] d,
                          input logic probeBusy);
    @(posedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    memDataIn = d;
    if (!wr) expQ.push_back(d);
    @(posedge clk); #1;
    if (probeBusy) begin
      reqAddr = ~a; reqWrite = ~wr;  // R8: request held during the access
    end else reqValid = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(reqReady == 1'b0, "R3 busy", 32'(reqReady), 32'd0);
      chk(memAddr == a, "R4/R6/R8 addr", 32'(memAddr), 32'(a));
      if (wr) begin
        chk(memWrN == (s != 2), "R4 wrN", 32'(memWrN), 32'(s != 2));
        chk(memDataOe == 1'b1 && memDataOut == d, "R5 data drive",
            {23'd0, memDataOe, memDataOut}, {23'd0, 1'b1, d});
        chk(memRdN == 1'b1, "R4 rdN", 32'(memRdN), 32'd1);
      end else begin
        chk(memRdN == !(s == 1 || s == 2), "R6 rdN", 32'(memRdN), 32'(!(s == 1 || s == 2)));
        chk(memDataOe == 1'b0, "R6 oe", 32'(memDataOe), 32'd0);
        chk(rspValid == (s == 3), "R7 pulse slot", 32'(rspValid), 32'(s == 3));
        if (s == 3) begin #1; memDataIn = ~d; end  // R7: late change ignored
      end
    end
    if (probeBusy) begin #1; reqValid = 1'b0; end
    @(negedge clk);
    chkIdle(wr ? "after write" : "after read");
    chk(rspValid == 1'b0, "R7 pulse ended", 32'(rspValid), 32'd0);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #12;
    chk(reqReady && memRdN && memWrN && !memDataOe && !rspValid, "R1 reset state",
        {27'd0, reqReady, memRdN, memWrN, memDataOe, rspValid}, 32'h1C);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 idle");
    portAddr = 16'hBEEF; portData = 8'h3C;
    @(negedge clk);
    chkIdle("R2 port follow");

    doAccess(1'b1, 16'h0000, 8'hA5, 1'b0);
    doAccess(1'b0, 16'hFFFF, 8'h96, 1'b0);
    doAccess(1'b0, 16'h8001, 8'h00, 1'b0);
    doAccess(1'b1, 16'h7FFE, 8'hFF, 1'b0);
    doAccess(1'b0, 16'h4321, 8'h5C, 1'b1);   // R8 busy probe on read
    // R8: nothing started after the held request
    repeat (3) begin
      @(negedge clk);
      chkIdle("R8 no extra access");
    end
    doAccess(1'b1, 16'h1111, 8'h42, 1'b1);   // R8 busy probe on write
    portAddr = 16'h0F0F; portData = 8'hE1;
    repeat (2) @(negedge clk);
    chkIdle("R2 final");
    chk(expQ.size() == 0, "R7 all reads answered", 32'(expQ.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule